// File: doc/BRIEF.md
# QoS-Class Read/Write Port Arbiter

This block sits in front of a multi-port memory controller. Each port can raise a read request and a write request. Each request carries a 4-bit AXI QoS value. The arbiter sorts every request into a traffic class.

- Reads fall into three classes: low-priority, video and high-priority.
- Writes fall into two classes: normal and video.

Video requests run an expiry countdown. Each port may also run an aging countdown that raises its priority when its request sits unserved. From these urgency flags the arbiter decides whether the controller serves reads or writes in this cycle. It then grants one port in that direction.

Requests behave as the valid side of a valid/ready pair:

- A port holds `rd_req`/`wr_req` and its QoS stable until it is granted.
- The grant is the ready and is given in the same cycle.
- Back-pressure comes from the credit inputs. While `rd_credit` (or `wr_credit`) is low, no read (or write) is granted, and the requests simply wait.

Within the chosen direction, ports are ranked by three keys, in this order:

1. Urgency (expired video timer or aged port).
2. The high-priority read class.
3. The QoS value.

Ties rotate round-robin.

Top module: `qos_port_arb`

## Requirements
- R1: Read QoS 12..15 is high-priority class, 4..11 is video class (timed), 0..3 is low class (never times out). In write direction, an enabled high-priority read with `rd_credit` high forces a switch to reads.
- R2: Write QoS 8..15 is video class (timed), 0..7 is normal class and never expires, even with a zero timeout.
- R3: A video request left ungranted for `tmo` consecutive cycles becomes urgent and outranks any non-urgent request. The counter reloads on grant or when the request is absent.
- R4: With `age_en` set, a request of that port left ungranted for `age_ld` consecutive cycles becomes urgent. The counter reloads on grant or when the request is absent.
- R5: In read direction the first matching rule decides, in this order:
  1. Urgent read with read credit: stay on reads.
  2. Otherwise, urgent write with write credit: switch to writes.
  3. Otherwise, any read with credit: stay on reads.
  4. Otherwise, any write with credit: switch to writes.
  5. Otherwise the direction holds.
- R6: In write direction the first matching rule decides, in this order:
  1. Urgent write with credit: stay on writes.
  2. Otherwise, urgent read with credit: switch to reads.
  3. Otherwise, high-priority read with credit: switch to reads.
  4. Otherwise, any write with credit: stay on writes.
  5. Otherwise, any read with credit: switch to reads.
  6. Otherwise the direction holds.
- R7: From reset the direction is read. With only ordinary reads and writes pending in read direction, the read wins.
- R8: Among non-urgent requests of one class level, the higher QoS value wins.
- R9: Equal-ranked ports are served round-robin. Each direction keeps its own pointer, which moves to the port after the last one granted.
- R10: A port whose `port_en` bit is low is never granted.
- R11: At most one port is granted per cycle, and only in a direction whose credit input is high.
- R12: After reset with no requests, `gnt_valid` is 0 and `dir_write` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | NPORT | Per-port enable |
| rd_req | input | NPORT | Read request (valid) per port |
| rd_qos | input | 4*NPORT | Read QoS, port i at bits [4i+3:4i] |
| wr_req | input | NPORT | Write request (valid) per port |
| wr_qos | input | 4*NPORT | Write QoS, port i at bits [4i+3:4i] |
| rd_tmo | input | TMO_W*NPORT | Video read timeout per port |
| wr_tmo | input | TMO_W*NPORT | Video write timeout per port |
| age_en | input | NPORT | Aging enable per port |
| rd_age_ld | input | AGE_W*NPORT | Read aging load per port |
| wr_age_ld | input | AGE_W*NPORT | Write aging load per port |
| rd_credit | input | 1 | Read queue has space |
| wr_credit | input | 1 | Write queue has space |
| gnt_valid | output | 1 | A grant is issued this cycle |
| gnt_write | output | 1 | The grant is a write |
| gnt_port | output | NPORT | One-hot granted port (ready) |
| dir_write | output | 1 | Direction served this cycle (1 = write) |

## Verification
The grant and `dir_write` are combinational results of this cycle's requests and the registered direction, timers and pointers. Each is therefore due in the same cycle as the stimulus that produces it. A new direction or pointer value shows only in the following cycle.

A timeout of T makes a continuously waiting video or aging request win in the (T+1)-th cycle of waiting.

The driver changes inputs 1 ns after a rising edge and queues the expected grant. The monitor compares it at the falling edge of that same cycle. Expected results for multi-cycle cases are queued one cycle at a time.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
  localparam int QOS_W      = 4;
  localparam int RD_VID_MIN = 4;
  localparam int RD_HI_MIN  = 12;
  localparam int WR_VID_MIN = 8;

  typedef enum logic [1:0] {RC_LOW = 2'd0, RC_VID = 2'd1, RC_HI = 2'd2} rd_cls_e;

  function automatic rd_cls_e rd_class(input logic [QOS_W-1:0] q);
    if (int'(q) >= RD_HI_MIN)       return RC_HI;
    else if (int'(q) >= RD_VID_MIN) return RC_VID;
    else                            return RC_LOW;
  endfunction

  function automatic logic wr_is_video(input logic [QOS_W-1:0] q);
    return int'(q) >= WR_VID_MIN;
  endfunction
endpackage

// File: rtl/qos_arb_down.sv
module qos_arb_down #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         reload,
  input  logic [W-1:0] load_val,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '1;
    else if (!active || reload) cnt_q <= load_val;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign hit = active && (cnt_q == '0);
endmodule

// File: rtl/qos_arb_pick.sv
module qos_arb_pick #(
  parameter int N  = 4,
  parameter int KW = 6,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    elig,
  input  logic [N*KW-1:0] keys,
  input  logic [IW-1:0]   ptr,
  output logic            found,
  output logic [N-1:0]    oh,
  output logic [IW-1:0]   idx
);
  logic [KW-1:0] best;
  logic          taken;

  always_comb begin
    found = 1'b0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || keys[i*KW +: KW] > best)) begin
        best  = keys[i*KW +: KW];
        found = 1'b1;
      end
    end
    oh    = '0;
    idx   = '0;
    taken = 1'b0;
    for (int k = 0; k < N; k++) begin
      int p;
      p = (int'(ptr) + k) % N;
      if (!taken && elig[p] && keys[p*KW +: KW] == best) begin
        oh[p] = 1'b1;
        idx   = IW'(p);
        taken = 1'b1;
      end
    end
  end
endmodule

// File: rtl/qos_arb_dir.sv
module qos_arb_dir (
  input  logic dir_q,
  input  logic urg_rd,
  input  logic urg_wr,
  input  logic hi_rd,
  input  logic any_rd,
  input  logic any_wr,
  input  logic rd_cr,
  input  logic wr_cr,
  output logic dir_nxt
);
  always_comb begin
    dir_nxt = dir_q;
    if (!dir_q) begin
      if (urg_rd && rd_cr)      dir_nxt = 1'b0;
      else if (urg_wr && wr_cr) dir_nxt = 1'b1;
      else if (any_rd && rd_cr) dir_nxt = 1'b0;
      else if (any_wr && wr_cr) dir_nxt = 1'b1;
    end else begin
      if (urg_wr && wr_cr)      dir_nxt = 1'b1;
      else if (urg_rd && rd_cr) dir_nxt = 1'b0;
      else if (hi_rd && rd_cr)  dir_nxt = 1'b0;
      else if (any_wr && wr_cr) dir_nxt = 1'b1;
      else if (any_rd && rd_cr) dir_nxt = 1'b0;
    end
  end
endmodule

// File: rtl/qos_port_arb.sv
module qos_port_arb
  import qos_arb_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int TMO_W = 11,
  parameter int AGE_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       port_en,
  input  logic [NPORT-1:0]       rd_req,
  input  logic [NPORT*QOS_W-1:0] rd_qos,
  input  logic [NPORT-1:0]       wr_req,
  input  logic [NPORT*QOS_W-1:0] wr_qos,
  input  logic [NPORT*TMO_W-1:0] rd_tmo,
  input  logic [NPORT*TMO_W-1:0] wr_tmo,
  input  logic [NPORT-1:0]       age_en,
  input  logic [NPORT*AGE_W-1:0] rd_age_ld,
  input  logic [NPORT*AGE_W-1:0] wr_age_ld,
  input  logic                   rd_credit,
  input  logic                   wr_credit,
  output logic                   gnt_valid,
  output logic                   gnt_write,
  output logic [NPORT-1:0]       gnt_port,
  output logic                   dir_write
);
  localparam int KW = QOS_W + 2;
  localparam int IW = $clog2(NPORT);

  logic [NPORT-1:0]    rd_ok, wr_ok, rd_urg, wr_urg, rd_hi;
  logic [NPORT-1:0]    rd_gnt, wr_gnt;
  logic [NPORT*KW-1:0] rd_keys, wr_keys;
  logic [NPORT-1:0]    rd_oh, wr_oh;
  logic [IW-1:0]       rd_idx, wr_idx, rd_ptr_q, wr_ptr_q;
  logic                rd_found, wr_found, rd_take, wr_take;
  logic                dir_q, dir_nxt;

  assign rd_ok = rd_req & port_en;
  assign wr_ok = wr_req & port_en;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic [QOS_W-1:0] rq, wq;
    rd_cls_e          rc;
    logic             r_vexp, r_aged, w_vexp, w_aged;

    assign rq = rd_qos[i*QOS_W +: QOS_W];
    assign wq = wr_qos[i*QOS_W +: QOS_W];
    assign rc = rd_class(rq);

    qos_arb_down #(.W(TMO_W)) u_rvid (
      .clk(clk), .rst_n(rst_n), .active(rd_ok[i] && rc == RC_VID),
      .reload(rd_gnt[i]), .load_val(rd_tmo[i*TMO_W +: TMO_W]), .hit(r_vexp));
    qos_arb_down #(.W(AGE_W)) u_rage (
      .clk(clk), .rst_n(rst_n), .active(rd_ok[i] && age_en[i]),
      .reload(rd_gnt[i]), .load_val(rd_age_ld[i*AGE_W +: AGE_W]), .hit(r_aged));
    qos_arb_down #(.W(TMO_W)) u_wvid (
      .clk(clk), .rst_n(rst_n), .active(wr_ok[i] && wr_is_video(wq)),
      .reload(wr_gnt[i]), .load_val(wr_tmo[i*TMO_W +: TMO_W]), .hit(w_vexp));
    qos_arb_down #(.W(AGE_W)) u_wage (
      .clk(clk), .rst_n(rst_n), .active(wr_ok[i] && age_en[i]),
      .reload(wr_gnt[i]), .load_val(wr_age_ld[i*AGE_W +: AGE_W]), .hit(w_aged));

    assign rd_urg[i] = r_vexp | r_aged;
    assign wr_urg[i] = w_vexp | w_aged;
    assign rd_hi[i]  = rd_ok[i] && rc == RC_HI;
    assign rd_keys[i*KW +: KW] = {rd_urg[i], rc == RC_HI, rq};
    assign wr_keys[i*KW +: KW] = {wr_urg[i], 1'b0, wq};
  end

  qos_arb_dir u_dir (
    .dir_q(dir_q), .urg_rd(|rd_urg), .urg_wr(|wr_urg), .hi_rd(|rd_hi),
    .any_rd(|rd_ok), .any_wr(|wr_ok), .rd_cr(rd_credit), .wr_cr(wr_credit),
    .dir_nxt(dir_nxt));

  qos_arb_pick #(.N(NPORT), .KW(KW)) u_rpick (
    .elig(rd_ok), .keys(rd_keys), .ptr(rd_ptr_q),
    .found(rd_found), .oh(rd_oh), .idx(rd_idx));
  qos_arb_pick #(.N(NPORT), .KW(KW)) u_wpick (
    .elig(wr_ok), .keys(wr_keys), .ptr(wr_ptr_q),
    .found(wr_found), .oh(wr_oh), .idx(wr_idx));

  assign rd_take   = !dir_nxt && rd_credit && rd_found;
  assign wr_take   = dir_nxt && wr_credit && wr_found;
  assign rd_gnt    = rd_take ? rd_oh : '0;
  assign wr_gnt    = wr_take ? wr_oh : '0;
  assign gnt_port  = rd_gnt | wr_gnt;
  assign gnt_valid = rd_take | wr_take;
  assign gnt_write = wr_take;
  assign dir_write = dir_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= 1'b0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
    end else begin
      dir_q <= dir_nxt;
      if (rd_take) rd_ptr_q <= (int'(rd_idx) == NPORT-1) ? '0 : rd_idx + 1'b1;
      if (wr_take) wr_ptr_q <= (int'(wr_idx) == NPORT-1) ? '0 : wr_idx + 1'b1;
    end
  end
endmodule

// File: rtl/qos_arb_chk.sv
module qos_arb_chk #(
  parameter int NPORT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] port_en,
  input logic [NPORT-1:0] rd_req,
  input logic [NPORT-1:0] wr_req,
  input logic             rd_credit,
  input logic             wr_credit,
  input logic             gnt_valid,
  input logic             gnt_write,
  input logic [NPORT-1:0] gnt_port,
  input logic             dir_write
);
  p_one_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_port) && (gnt_valid == (gnt_port != '0)));

  p_no_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_port & ~port_en) == '0);

  p_rd_credit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_write) |-> (rd_credit && (gnt_port & rd_req) != '0));

  p_wr_credit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_write) |-> (wr_credit && (gnt_port & wr_req) != '0));

  p_dir_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_write == dir_write));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_req | wr_req) == '0) |-> !gnt_valid);
endmodule

bind qos_port_arb qos_arb_chk #(.NPORT(NPORT)) chk_i (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .rd_req(rd_req), .wr_req(wr_req),
  .rd_credit(rd_credit), .wr_credit(wr_credit), .gnt_valid(gnt_valid),
  .gnt_write(gnt_write), .gnt_port(gnt_port), .dir_write(dir_write));

// File: tb/qos_port_arb_tb_top.sv
module qos_port_arb_tb_top;
  localparam int NP = 4;
  localparam int TW = 11;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    port_en, rd_req, wr_req, age_en;
  logic [NP*4-1:0]  rd_qos, wr_qos;
  logic [NP*TW-1:0] rd_tmo, wr_tmo;
  logic [NP*AW-1:0] rd_age_ld, wr_age_ld;
  logic rd_credit, wr_credit;
  logic gnt_valid, gnt_write, dir_write;
  logic [NP-1:0] gnt_port;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct packed {
    logic          vld;
    logic          wr;
    logic [NP-1:0] oh;
    logic          dir;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  qos_port_arb #(.NPORT(NP), .TMO_W(TW), .AGE_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .rd_req(rd_req), .rd_qos(rd_qos),
    .wr_req(wr_req), .wr_qos(wr_qos), .rd_tmo(rd_tmo), .wr_tmo(wr_tmo),
    .age_en(age_en), .rd_age_ld(rd_age_ld), .wr_age_ld(wr_age_ld),
    .rd_credit(rd_credit), .wr_credit(wr_credit), .gnt_valid(gnt_valid),
    .gnt_write(gnt_write), .gnt_port(gnt_port), .dir_write(dir_write));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_now(logic v, logic w, logic [NP-1:0] oh, logic d, string tag);
    exp_t e;
    e.vld = v; e.wr = w; e.oh = oh; e.dir = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic no_req();
    rd_req = '0; wr_req = '0; rd_qos = '0; wr_qos = '0;
  endtask

  task automatic rd(int p, logic [3:0] q);
    rd_req[p] = 1'b1; rd_qos[p*4 +: 4] = q;
  endtask

  task automatic wr(int p, logic [3:0] q);
    wr_req[p] = 1'b1; wr_qos[p*4 +: 4] = q;
  endtask

  task automatic idle_cycle();
    tick(); no_req();
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      exp_t  a;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a.vld = gnt_valid; a.wr = gnt_write; a.oh = gnt_port; a.dir = dir_write;
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s: got vld=%b wr=%b port=%b dir=%b, expected vld=%b wr=%b port=%b dir=%b",
                 t, a.vld, a.wr, a.oh, a.dir, e.vld, e.wr, e.oh, e.dir);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    port_en = '1; age_en = '0; rd_credit = 1'b1; wr_credit = 1'b1;
    no_req();
    for (int i = 0; i < NP; i++) begin
      rd_tmo[i*TW +: TW] = TW'(100); wr_tmo[i*TW +: TW] = TW'(100);
      rd_age_ld[i*AW +: AW] = AW'(100); wr_age_ld[i*AW +: AW] = AW'(100);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12: idle after reset
    tick(); expect_now(0, 0, 4'b0000, 0, "R12");
    // R8: highest QoS wins
    tick(); rd(0, 2); rd(1, 9); rd(2, 5); expect_now(1, 0, 4'b0010, 0, "R8");
    // R9: round robin from pointer 2
    tick(); no_req(); for (int i = 0; i < NP; i++) rd(i, 1); expect_now(1, 0, 4'b0100, 0, "R9");
    tick(); expect_now(1, 0, 4'b1000, 0, "R9");
    tick(); expect_now(1, 0, 4'b0001, 0, "R9");
    tick(); expect_now(1, 0, 4'b0010, 0, "R9");
    // R10: disabled ports skipped, pointer at 2
    tick(); port_en = 4'b0011; expect_now(1, 0, 4'b0001, 0, "R10");
    tick(); port_en = 4'b0000; expect_now(0, 0, 4'b0000, 0, "R10");
    tick(); port_en = '1; no_req();
    // R7: read wins in read direction
    tick(); rd(0, 0); wr(1, 15); expect_now(1, 0, 4'b0001, 0, "R7");
    // R5: no read credit, pending write switches
    tick(); rd_credit = 1'b0; no_req(); rd(0, 0); wr(1, 3); expect_now(1, 1, 4'b0010, 1, "R5");
    // R6: ordinary writes keep write direction
    tick(); rd_credit = 1'b1; expect_now(1, 1, 4'b0010, 1, "R6");
    // R1: high-priority read switches from write
    tick(); no_req(); rd(0, 13); wr(1, 3); expect_now(1, 0, 4'b0001, 0, "R1");
    // R6: write credit exhausted returns to reads
    tick(); rd_credit = 1'b0; no_req(); wr(1, 3); expect_now(1, 1, 4'b0010, 1, "R5");
    tick(); rd_credit = 1'b1; wr_credit = 1'b0; rd(0, 0); expect_now(1, 0, 4'b0001, 0, "R6");
    // R11: no credit, no grant
    tick(); rd_credit = 1'b0; expect_now(0, 0, 4'b0000, 0, "R11");
    tick(); rd_credit = 1'b1; wr_credit = 1'b1; no_req(); rd_tmo[1*TW +: TW] = TW'(3);
    // R3: video read expires after 3 waiting cycles
    tick(); rd(0, 15); rd(1, 4); expect_now(1, 0, 4'b0001, 0, "R3");
    tick(); expect_now(1, 0, 4'b0001, 0, "R3");
    tick(); expect_now(1, 0, 4'b0001, 0, "R3");
    tick(); expect_now(1, 0, 4'b0010, 0, "R3");
    tick(); no_req(); wr_tmo[2*TW +: TW] = TW'(2);
    // R5: expired video write switches from reads
    tick(); rd(0, 0); wr(2, 8); expect_now(1, 0, 4'b0001, 0, "R5");
    tick(); expect_now(1, 0, 4'b0001, 0, "R5");
    tick(); expect_now(1, 1, 4'b0100, 1, "R5");
    idle_cycle();
    // R2: normal write never expires, video write with zero timeout does
    tick(); rd(0, 0); wr_tmo[3*TW +: TW] = '0; expect_now(1, 0, 4'b0001, 0, "R2");
    tick(); wr(3, 7); expect_now(1, 0, 4'b0001, 0, "R2");
    tick(); wr(3, 8); expect_now(1, 1, 4'b1000, 1, "R2");
    idle_cycle();
    tick(); rd(0, 0); age_en[1] = 1'b1; rd_age_ld[1*AW +: AW] = AW'(2);
    expect_now(1, 0, 4'b0001, 0, "R4");
    // R4: aged low-QoS port beats higher QoS
    tick(); no_req(); rd(0, 10); rd(1, 0); expect_now(1, 0, 4'b0001, 0, "R4");
    tick(); expect_now(1, 0, 4'b0001, 0, "R4");
    tick(); expect_now(1, 0, 4'b0010, 0, "R4");
    tick(); no_req();
    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule